// File: doc/BRIEF.md
# Serial Audio Link Output Frame Packer

This block sits on the controller side of a serial audio codec link. Once per frame it takes a register command and a set of playback samples and builds a 256-bit output frame. It then shifts that frame out one bit per bit clock, most significant bit first, and drives a frame sync pulse alongside it. A frame is a 16-bit tag slot followed by twelve 20-bit slots.

- Slot 1 carries the command address.
- Slot 2 carries the command write data.
- Slots 3 and 4 carry the left and right playback samples.
- Slots 6 to 9 carry the centre, left-surround, right-surround and low-frequency samples.
- Slots 5 and 10 to 12 are always zero.

The block does more than serialise the raw words. Every bit position that carries no valid data is zero-stuffed. This depends on the command type (a read clears the data slot) and on the selected sample resolution (bits below the valid sample width are cleared). The inputs are sampled on the rising edge that starts a frame. They may change freely at any other time.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame is 256 bits, sent MSB first. Frame bit 255−k is on `sdata_out` after the k-th rising edge of the frame. All inputs are sampled on the edge that starts the frame (k = 0), and input changes later in the frame have no effect on that frame. A new frame starts on the edge after bit 0 of the previous frame.
- R2: `sync` is high after edges k = 0 to 15 of every frame, and low after edges 16 to 255.
- R3: Tag slot (frame bits 255:240):
  - Bit 15 is the OR of all slot-valid bits.
  - Bit 15−n is the valid bit of slot n, for n = 1 to 12.
  - Bits 2:0 are zero.
  - Slot 1 is valid when `cmd_valid` is high.
  - Slot 2 is valid when `cmd_valid` is high and `cmd_read` is low.
  - Slots 3 and 4 follow `pcm_valid`. Slot 6 follows `ctr_valid`. Slots 7 and 8 follow `sur_valid`. Slot 9 follows `lfe_valid`.
  - Slots 5 and 10 to 12 are never valid.
- R4: Slot 1 layout:
  - Bit 19 is `cmd_read` (1 = read).
  - Bits 18:12 are `cmd_addr`.
  - Bits 11:0 are zero.
- R5: Slot 2 carries `cmd_wdata` in bits 19:4, and bits 3:0 are zero. On a read the whole slot is zero.
- R6: Slots 3 and 4 carry `pcm_left` and `pcm_right`, left-justified. `pcm_res` selects the resolution: 0 = 16 bits (bits 3:0 cleared), 1 = 18 bits (bits 1:0 cleared), 2 or 3 = 20 bits.
- R7: Slots 6, 7, 8 and 9 carry `ctr_sample`, `sur_left`, `sur_right` and `lfe_sample`. The same resolution clearing as in R6 applies to them.
- R8: Slot 5, slots 10 to 12, and any slot whose valid bit is clear are sent as all zeros, whatever the data inputs hold.
- R9: While `rst_n` is low, `sync` and `sdata_out` are 0. The first frame starts on the first rising edge after reset is released, and this also holds after a reset in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A register command is sent in this frame |
| cmd_read | input | 1 | Command type, 1 = read, 0 = write |
| cmd_addr | input | 7 | Register index |
| cmd_wdata | input | 16 | Register write data |
| pcm_valid | input | 1 | Left and right samples are valid |
| pcm_res | input | 2 | Sample resolution select |
| pcm_left | input | 20 | Left playback sample, left-justified |
| pcm_right | input | 20 | Right playback sample, left-justified |
| ctr_valid | input | 1 | Centre sample is valid |
| ctr_sample | input | 20 | Centre sample |
| sur_valid | input | 1 | Surround pair is valid |
| sur_left | input | 20 | Left-surround sample |
| sur_right | input | 20 | Right-surround sample |
| lfe_valid | input | 1 | Low-frequency sample is valid |
| lfe_sample | input | 20 | Low-frequency sample |
| sync | output | 1 | Frame sync, high during the tag slot |
| sdata_out | output | 1 | Serial frame data, MSB first |

## Verification
Every output bit is due exactly one register stage after its edge. The frame captured at edge 0 shows its bit 255 after that same edge, and bit 255−k after edge k. The next frame's inputs are taken on the edge that follows frame bit 0. The bench drives inputs and samples `sdata_out` and `sync` on the falling edge after each rising edge, and collects all 256 bits before comparing them slot by slot. A reset test checks that the first frame bit shows after the first edge once reset is released. Inputs changed at bit 100 of a frame are checked not to appear until the next frame.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

    typedef enum logic [1:0] {
        RES_W16  = 2'd0,
        RES_W18  = 2'd1,
        RES_W20  = 2'd2,
        RES_W20X = 2'd3
    } res_e;

    localparam int RES_LO_BITS  = 16;
    localparam int RES_MID_BITS = 18;

endpackage

// File: rtl/pcm_slot_masker.sv
module pcm_slot_masker
    import aclink_pkg::*;
#(
    parameter int SLOT_W = 20
) (
    input  logic [SLOT_W-1:0] sample_in,
    input  logic [1:0]        res_sel,
    output logic [SLOT_W-1:0] slot_out
);
    localparam int TRAIL_LO  = SLOT_W - RES_LO_BITS;
    localparam int TRAIL_MID = SLOT_W - RES_MID_BITS;

    logic [SLOT_W-1:0] keep_mask;

    always_comb begin
        case (res_e'(res_sel))
            RES_W16: keep_mask = {SLOT_W{1'b1}} << TRAIL_LO;
            RES_W18: keep_mask = {SLOT_W{1'b1}} << TRAIL_MID;
            default: keep_mask = {SLOT_W{1'b1}};
        endcase
        slot_out = sample_in & keep_mask;
    end
endmodule

// File: rtl/cmd_slot_builder.sv
module cmd_slot_builder #(
    parameter int SLOT_W = 20,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [SLOT_W-1:0] slot_addr,
    output logic [SLOT_W-1:0] slot_data
);
    localparam int DATA_PAD = SLOT_W - DATA_W;

    always_comb begin
        slot_addr                         = '0;
        slot_addr[SLOT_W-1]               = cmd_read;
        slot_addr[SLOT_W-2 -: ADDR_W]     = cmd_addr;
        slot_data                         = '0;
        if (!cmd_read) begin
            slot_data[SLOT_W-1 -: DATA_W] = cmd_wdata;
        end
    end

    initial begin
        assert (DATA_PAD >= 0 && ADDR_W < SLOT_W)
            else $error("command fields do not fit the slot");
    end
endmodule

// File: rtl/frame_assembler.sv
module frame_assembler #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 12,
    localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W
) (
    input  logic [N_SLOTS-1:0]        slot_vld,
    input  logic [N_SLOTS*SLOT_W-1:0] slot_flat,
    output logic [FRAME_W-1:0]        frame
);
    always_comb begin
        frame            = '0;
        frame[FRAME_W-1] = |slot_vld;
        for (int i = 0; i < N_SLOTS; i++) begin
            frame[FRAME_W-2-i] = slot_vld[i];
            if (slot_vld[i]) begin
                frame[FRAME_W-TAG_W-1-i*SLOT_W -: SLOT_W] = slot_flat[i*SLOT_W +: SLOT_W];
            end
        end
    end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int FRAME_W = 256,
    parameter int TAG_W   = 16,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               sync,
    output logic               sdata
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_W - 1);
    localparam logic [CNT_W-1:0] TAG_LEN  = CNT_W'(TAG_W);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
        logic               sync;
        logic               sdo;
    } shift_state_t;

    shift_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.cnt == LAST_BIT) begin
            nxt_d.cnt   = '0;
            nxt_d.sdo   = frame_in[FRAME_W-1];
            nxt_d.shreg = {frame_in[FRAME_W-2:0], 1'b0};
            nxt_d.sync  = 1'b1;
        end else begin
            nxt_d.cnt   = cur_q.cnt + 1'b1;
            nxt_d.sdo   = cur_q.shreg[FRAME_W-1];
            nxt_d.shreg = {cur_q.shreg[FRAME_W-2:0], 1'b0};
            nxt_d.sync  = (nxt_d.cnt < TAG_LEN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.cnt   <= LAST_BIT;
            cur_q.shreg <= '0;
            cur_q.sync  <= 1'b0;
            cur_q.sdo   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sync  = cur_q.sync;
    assign sdata = cur_q.sdo;

    AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cnt == LAST_BIT) |=> (sync && sdata == $past(frame_in[FRAME_W-1]))); // R1

    AST_SYNC_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cnt == TAG_END) |=> !sync); // R2

    AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && cur_q.cnt != TAG_END) |=> sync); // R2
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 12,
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 16
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              pcm_valid,
    input  logic [1:0]        pcm_res,
    input  logic [SLOT_W-1:0] pcm_left,
    input  logic [SLOT_W-1:0] pcm_right,
    input  logic              ctr_valid,
    input  logic [SLOT_W-1:0] ctr_sample,
    input  logic              sur_valid,
    input  logic [SLOT_W-1:0] sur_left,
    input  logic [SLOT_W-1:0] sur_right,
    input  logic              lfe_valid,
    input  logic [SLOT_W-1:0] lfe_sample,
    output logic              sync,
    output logic              sdata_out
);
    localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W;
    localparam int N_PCM   = 6;
    localparam int PCM_SLOT_NUM [N_PCM] = '{3, 4, 6, 7, 8, 9};
    localparam int CTR_HI  = FRAME_W - TAG_W - 1 - 5 * SLOT_W;

    logic [SLOT_W-1:0]         pcm_raw [N_PCM];
    logic                      pcm_vld [N_PCM];
    logic [SLOT_W-1:0]         pcm_out [N_PCM];
    logic [SLOT_W-1:0]         cmd_addr_slot;
    logic [SLOT_W-1:0]         cmd_data_slot;
    logic [N_SLOTS-1:0]        slot_vld;
    logic [N_SLOTS*SLOT_W-1:0] slot_flat;
    logic [FRAME_W-1:0]        frame_w;

    assign pcm_raw[0] = pcm_left;   assign pcm_vld[0] = pcm_valid;
    assign pcm_raw[1] = pcm_right;  assign pcm_vld[1] = pcm_valid;
    assign pcm_raw[2] = ctr_sample; assign pcm_vld[2] = ctr_valid;
    assign pcm_raw[3] = sur_left;   assign pcm_vld[3] = sur_valid;
    assign pcm_raw[4] = sur_right;  assign pcm_vld[4] = sur_valid;
    assign pcm_raw[5] = lfe_sample; assign pcm_vld[5] = lfe_valid;

    for (genvar g = 0; g < N_PCM; g++) begin : g_pcm
        pcm_slot_masker #(.SLOT_W(SLOT_W)) u_mask (
            .sample_in (pcm_raw[g]),
            .res_sel   (pcm_res),
            .slot_out  (pcm_out[g])
        );
    end

    cmd_slot_builder #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .cmd_read  (cmd_read),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .slot_addr (cmd_addr_slot),
        .slot_data (cmd_data_slot)
    );

    always_comb begin
        slot_vld                   = '0;
        slot_flat                  = '0;
        slot_vld[0]                = cmd_valid;
        slot_flat[0 +: SLOT_W]     = cmd_addr_slot;
        slot_vld[1]                = cmd_valid & ~cmd_read;
        slot_flat[SLOT_W +: SLOT_W] = cmd_data_slot;
        for (int g = 0; g < N_PCM; g++) begin
            slot_vld[PCM_SLOT_NUM[g]-1]                     = pcm_vld[g];
            slot_flat[(PCM_SLOT_NUM[g]-1)*SLOT_W +: SLOT_W] = pcm_out[g];
        end
    end

    frame_assembler #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_asm (
        .slot_vld  (slot_vld),
        .slot_flat (slot_flat),
        .frame     (frame_w)
    );

    frame_shifter #(.FRAME_W(FRAME_W), .TAG_W(TAG_W)) u_shift (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .frame_in (frame_w),
        .sync     (sync),
        .sdata    (sdata_out)
    );

    AST_READ_CLEARS_DATA: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (cmd_valid && cmd_read) |-> (cmd_data_slot == '0)); // R5

    AST_RES16_TRAIL_ZERO: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pcm_res == 2'd0) |-> (pcm_out[0][3:0] == 4'h0 && pcm_out[1][3:0] == 4'h0)); // R6

    AST_IDLE_CTR_ZERO: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (!ctr_valid) |-> (frame_w[CTR_HI -: SLOT_W] == '0)); // R8
endmodule

// File: tb/aclink_tx_framer_test.sv
`timescale 1ns/1ps
module aclink_tx_framer_test;

    typedef struct packed {
        logic        cmd_v;
        logic        rd;
        logic [6:0]  addr;
        logic [15:0] wdata;
        logic        pcm_v;
        logic [1:0]  res;
        logic [19:0] left;
        logic [19:0] right;
        logic        ctr_v;
        logic [19:0] ctr;
        logic        sur_v;
        logic [19:0] sl;
        logic [19:0] sr;
        logic        lfe_v;
        logic [19:0] lfe;
    } vec_t;

    localparam int N_VEC = 6;
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 1'b0, 7'h02, 16'h8000, 1'b1, 2'd2, 20'hABCDE, 20'h12345,
          1'b0, 20'h11111, 1'b0, 20'h22222, 20'h33333, 1'b0, 20'h44444},
        '{1'b1, 1'b1, 7'h7C, 16'hFFFF, 1'b1, 2'd0, 20'hFFFFF, 20'h8000F,
          1'b1, 20'hFFFFF, 1'b0, 20'h0F0F0, 20'h0F0F0, 1'b0, 20'h00001},
        '{1'b0, 1'b0, 7'h7F, 16'hDEAD, 1'b1, 2'd1, 20'hFFFFF, 20'h5A5A5,
          1'b0, 20'h77777, 1'b1, 20'h0000F, 20'hFFFFF, 1'b1, 20'h3FFFF},
        '{1'b0, 1'b1, 7'h55, 16'hBEEF, 1'b0, 2'd2, 20'hFFFFF, 20'hFFFFF,
          1'b0, 20'hFFFFF, 1'b0, 20'hFFFFF, 20'hFFFFF, 1'b0, 20'hFFFFF},
        '{1'b1, 1'b0, 7'h7F, 16'hFFFF, 1'b1, 2'd3, 20'h80001, 20'h7FFFF,
          1'b1, 20'hC0003, 1'b1, 20'hFFFFF, 20'hFFFFF, 1'b1, 20'hFFFFF},
        '{1'b1, 1'b0, 7'h00, 16'h0001, 1'b0, 2'd0, 20'hFFFFF, 20'hFFFFF,
          1'b0, 20'h12345, 1'b1, 20'hFFFFF, 20'h8000F, 1'b0, 20'hFFFFF}
    };

    logic        bit_clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_read, pcm_valid, ctr_valid, sur_valid, lfe_valid;
    logic [6:0]  cmd_addr;
    logic [15:0] cmd_wdata;
    logic [1:0]  pcm_res;
    logic [19:0] pcm_left, pcm_right, ctr_sample, sur_left, sur_right, lfe_sample;
    logic        sync, sdata_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 bit_clk = ~bit_clk;

    aclink_tx_framer uut (
        .bit_clk(bit_clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .pcm_valid(pcm_valid), .pcm_res(pcm_res), .pcm_left(pcm_left), .pcm_right(pcm_right),
        .ctr_valid(ctr_valid), .ctr_sample(ctr_sample),
        .sur_valid(sur_valid), .sur_left(sur_left), .sur_right(sur_right),
        .lfe_valid(lfe_valid), .lfe_sample(lfe_sample),
        .sync(sync), .sdata_out(sdata_out)
    );

    task automatic check(input string req, input string what,
                         input logic [255:0] got, input logic [255:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cmd_valid = v.cmd_v; cmd_read = v.rd; cmd_addr = v.addr; cmd_wdata = v.wdata;
        pcm_valid = v.pcm_v; pcm_res = v.res; pcm_left = v.left; pcm_right = v.right;
        ctr_valid = v.ctr_v; ctr_sample = v.ctr;
        sur_valid = v.sur_v; sur_left = v.sl; sur_right = v.sr;
        lfe_valid = v.lfe_v; lfe_sample = v.lfe;
    endtask

    function automatic logic [255:0] expect_frame(input vec_t v);
        logic [19:0]  m;
        logic [19:0]  s [1:12];
        logic [11:0]  vl;
        logic [15:0]  tag;
        logic [255:0] f;
        m = (v.res == 2'd0) ? 20'hFFFF0 : (v.res == 2'd1) ? 20'hFFFFC : 20'hFFFFF;
        for (int n = 1; n <= 12; n++) s[n] = '0;
        vl = '0;
        if (v.cmd_v) begin
            vl[0] = 1'b1;
            s[1]  = {v.rd, v.addr, 12'h000};
            if (!v.rd) begin vl[1] = 1'b1; s[2] = {v.wdata, 4'h0}; end
        end
        if (v.pcm_v) begin vl[2] = 1'b1; vl[3] = 1'b1; s[3] = v.left & m; s[4] = v.right & m; end
        if (v.ctr_v) begin vl[5] = 1'b1; s[6] = v.ctr & m; end
        if (v.sur_v) begin vl[6] = 1'b1; vl[7] = 1'b1; s[7] = v.sl & m; s[8] = v.sr & m; end
        if (v.lfe_v) begin vl[8] = 1'b1; s[9] = v.lfe & m; end
        tag     = '0;
        tag[15] = |vl;
        for (int n = 1; n <= 12; n++) tag[15-n] = vl[n-1];
        f = {tag, 240'h0};
        for (int n = 1; n <= 12; n++) f[239-20*(n-1) -: 20] = s[n];
        return f;
    endfunction

    function automatic logic [19:0] slot_of(input logic [255:0] f, input int n);
        return f[239-20*(n-1) -: 20];
    endfunction

    task automatic capture(input int change_at, input vec_t alt,
                           output logic [255:0] bits, output logic [255:0] syncs);
        for (int k = 0; k < 256; k++) begin
            @(posedge bit_clk);
            @(negedge bit_clk);
            bits[255-k]  = sdata_out;
            syncs[255-k] = sync;
            if (k == change_at) apply(alt);
        end
    endtask

    task automatic compare_frame(input string tagname, input logic [255:0] got,
                                 input logic [255:0] syncs, input vec_t v);
        logic [255:0] e;
        e = expect_frame(v);
        check("R1", {tagname, " whole frame"}, got, e);
        check("R2", {tagname, " sync window"}, syncs, {16'hFFFF, 240'h0});
        check("R3", {tagname, " tag slot"}, 256'(got[255:240]), 256'(e[255:240]));
        check("R4", {tagname, " slot1"}, 256'(slot_of(got, 1)), 256'(slot_of(e, 1)));
        check("R5", {tagname, " slot2"}, 256'(slot_of(got, 2)), 256'(slot_of(e, 2)));
        check("R6", {tagname, " slots3-4"}, 256'({slot_of(got, 3), slot_of(got, 4)}),
              256'({slot_of(e, 3), slot_of(e, 4)}));
        check("R7", {tagname, " slots6-9"},
              256'({slot_of(got, 6), slot_of(got, 7), slot_of(got, 8), slot_of(got, 9)}),
              256'({slot_of(e, 6), slot_of(e, 7), slot_of(e, 8), slot_of(e, 9)}));
        check("R8", {tagname, " reserved slots"},
              256'({slot_of(got, 5), slot_of(got, 10), slot_of(got, 11), slot_of(got, 12)}), 256'h0);
    endtask

    initial begin
        repeat (150000) @(posedge bit_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [255:0] bits, syncs;
        rst_n = 1'b0;
        apply(VECS[0]);
        repeat (4) @(posedge bit_clk);
        @(negedge bit_clk);
        // R9: reset state of the outputs
        check("R9", "reset outputs", 256'({sync, sdata_out}), 256'h0);
        rst_n = 1'b1;

        // R1..R8 table walk; the first frame also checks the start after reset (R9)
        for (int i = 0; i < N_VEC; i++) begin
            apply(VECS[i]);
            capture(-1, VECS[i], bits, syncs);
            compare_frame($sformatf("vec%0d", i), bits, syncs, VECS[i]);
        end

        // R1: inputs changed in mid-frame do not reach the current frame
        apply(VECS[4]);
        capture(100, VECS[3], bits, syncs);
        check("R1", "mid-frame change ignored", bits, expect_frame(VECS[4]));
        capture(-1, VECS[3], bits, syncs);
        check("R1", "change lands in next frame", bits, expect_frame(VECS[3]));

        // R9: reset in the middle of a frame, then a clean restart
        apply(VECS[2]);
        for (int k = 0; k < 40; k++) begin @(posedge bit_clk); @(negedge bit_clk); end
        rst_n = 1'b0;
        @(posedge bit_clk);
        @(negedge bit_clk);
        check("R9", "mid-frame reset outputs", 256'({sync, sdata_out}), 256'h0);
        apply(VECS[4]);
        rst_n = 1'b1;
        capture(-1, VECS[4], bits, syncs);
        check("R9", "restart frame", bits, expect_frame(VECS[4]));
        check("R9", "restart sync", syncs, {16'hFFFF, 240'h0});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule